// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block is the interrupt control path of a small 8-bit processor core. It holds one pending flag per interrupt source. Each flag is gated by an enable for that source and by a global enable bit kept in the core's status byte. When the core reports an instruction boundary and a qualified request exists, the sequencer takes over for three cycles. During those cycles it stalls fetch and saves the address of the next instruction in a small internal byte stack. It then asks the core to load the program counter with the vector of the winning source.

A return strobe runs the reverse path. The saved address is read back from the stack and handed to the core as a jump target, and the global enable is set again. Saving working registers and the status byte stays with the handler code. The core's decoder is modelled as strobes: boundary, return, enable set and clear, and status write.

Top module: `irq_sequencer`

## Requirements
- R1: A pending source is taken only when its `irq_en` bit and the global enable (status bit 7) are both 1 at a cycle where `boundary` is high and the sequencer is idle. No entry starts otherwise.
- R2: A pulse on `irq_req[i]` sets `pending[i]` on the next edge even while source i or the global enable is masked. A masked pending flag stays set without starting entry.
- R3: An entry keeps `busy` high for exactly the three cycles after the accepting edge. `boundary` and `reti` are ignored while `busy` is high.
- R4: The accepting edge clears status bit 7.
- R5: After reset the stack pointer is all ones. Entry writes `next_pc[7:0]` at the pointer and `next_pc[15:8]` one byte below it, decrementing the pointer after each byte, so it ends two lower.
- R6: In the third busy cycle of an entry, `pc_load` is 1 for one cycle and `pc_target` is `VEC_BASE + i*VEC_STRIDE` for the winning source i (default 0x0002 + 2i).
- R7: A source whose bit in `VEC_MASK` is 0 (by default source 3) sends `pc_target` to 0x0000.
- R8: Among pending and enabled sources the lowest index wins. Only its pending flag is cleared at acceptance, and the others stay set.
- R9: A `reti` strobe while idle pops the high byte and then the low byte, raising the pointer by two. In the third busy cycle it asserts `pc_load` with the saved address. Status bit 7 is 1 on the following cycle.
- R10: `gie_set` sets and `gie_clr` clears status bit 7 on the next edge. When both are high, clear wins.
- R11: `sreg_we` replaces the whole status byte with `sreg_wdata`. An enable strobe in the same cycle overrides bit 7 of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | NSRC | Request pulses, one per source |
| irq_en | input | NSRC | Per-source enables |
| boundary | input | 1 | High in the cycle that ends an instruction |
| next_pc | input | 16 | Address of the next instruction to run |
| reti | input | 1 | Return-from-interrupt strobe |
| gie_set | input | 1 | Set global enable |
| gie_clr | input | 1 | Clear global enable |
| sreg_we | input | 1 | Status byte write strobe |
| sreg_wdata | input | 8 | Status byte write data |
| sreg | output | 8 | Status byte, bit 7 is global enable |
| pending | output | NSRC | Pending flags |
| busy | output | 1 | Stall fetch |
| pc_load | output | 1 | Load program counter this cycle |
| pc_target | output | 16 | Program counter value to load |
| sp | output | SPW | Stack pointer |

## Verification
The assertions assume that the core raises `reti` only when a matching entry has been made, so the stack never underflows. They also assume it keeps no more nested entries than the stack can hold. The stimulus nests at most two entries and returns from each exactly once. It pulses strobes for a single cycle away from the clock edge, and it raises `boundary` only while the sequencer is idle, except in the one test that probes the ignore rule.

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
  parameter int NSRC = 4,
  parameter int SPW = 4,
  parameter int GIE_BIT = 7,
  parameter logic [15:0] VEC_BASE = 16'h0002,
  parameter int VEC_STRIDE = 2,
  parameter logic [NSRC-1:0] VEC_MASK = 4'b0111,
  parameter logic [15:0] RESET_PC = 16'h0000
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_req,
  input  logic [NSRC-1:0] irq_en,
  input  logic            boundary,
  input  logic [15:0]     next_pc,
  input  logic            reti,
  input  logic            gie_set,
  input  logic            gie_clr,
  input  logic            sreg_we,
  input  logic [7:0]      sreg_wdata,
  output logic [7:0]      sreg,
  output logic [NSRC-1:0] pending,
  output logic            busy,
  output logic            pc_load,
  output logic [15:0]     pc_target,
  output logic [SPW-1:0]  sp
);
  localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;
  localparam int DEPTH = 1 << SPW;

  typedef enum logic [2:0] {S_IDLE, S_PUSH_LO, S_PUSH_HI, S_JUMP, S_POP_HI, S_POP_LO, S_RJUMP} st_t;

  st_t state;
  logic [15:0] ret_pc, tgt;
  logic [7:0] stk [DEPTH];
  logic [NSRC-1:0] ready, win;
  logic [IW-1:0] win_idx;
  logic [15:0] vec;
  logic [7:0] sreg_d;
  logic idle, accept, start_ret;
  logic [SPW-1:0] sp_up;

  assign ready = pending & irq_en;
  assign idle = (state == S_IDLE);
  assign accept = idle && boundary && !reti && sreg[GIE_BIT] && (|ready);
  assign start_ret = idle && reti;
  assign sp_up = sp + 1'b1;
  assign busy = !idle;
  assign pc_load = (state == S_JUMP) || (state == S_RJUMP);
  assign pc_target = tgt;

  always_comb begin
    win = '0;
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (ready[i]) begin
        win = '0;
        win[i] = 1'b1;
        win_idx = IW'(i);
      end
    end
    vec = VEC_MASK[win_idx] ? VEC_BASE + 16'(win_idx) * 16'(VEC_STRIDE) : RESET_PC;
  end

  always_comb begin
    sreg_d = sreg_we ? sreg_wdata : sreg;
    if (gie_set) sreg_d[GIE_BIT] = 1'b1;
    if (gie_clr) sreg_d[GIE_BIT] = 1'b0;
    if (accept) sreg_d[GIE_BIT] = 1'b0;
    if (state == S_RJUMP) sreg_d[GIE_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sreg <= '0;
      pending <= '0;
      sp <= '1;
      ret_pc <= '0;
      tgt <= '0;
    end else begin
      sreg <= sreg_d;
      pending <= (pending & ~(accept ? win : '0)) | irq_req;
      case (state)
        S_IDLE: begin
          if (start_ret) state <= S_POP_HI;
          else if (accept) begin
            ret_pc <= next_pc;
            tgt <= vec;
            state <= S_PUSH_LO;
          end
        end
        S_PUSH_LO: begin sp <= sp - 1'b1; state <= S_PUSH_HI; end
        S_PUSH_HI: begin sp <= sp - 1'b1; state <= S_JUMP; end
        S_POP_HI: begin tgt[15:8] <= stk[sp_up]; sp <= sp_up; state <= S_POP_LO; end
        S_POP_LO: begin tgt[7:0] <= stk[sp_up]; sp <= sp_up; state <= S_RJUMP; end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (state == S_PUSH_LO) stk[sp] <= ret_pc[7:0];
    if (state == S_PUSH_HI) stk[sp] <= ret_pc[15:8];
  end

  a_r1_no_entry_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !sreg[GIE_BIT]) |=> (state != S_PUSH_LO));
  a_r3_pcload_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |-> busy);
  a_r4_entry_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_PUSH_LO) |-> !sreg[GIE_BIT]);
  a_r5_push_two_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_JUMP) |-> (sp == $past(sp, 2) - SPW'(2)));
  a_r8_winner_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> ((pending & $past(win & ~irq_req)) == '0));
  a_r9_return_sets_gie: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_RJUMP) |=> sreg[GIE_BIT]);
  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (gie_set && gie_clr && state != S_RJUMP) |=> !sreg[GIE_BIT]);
endmodule

// File: tb/irq_sequencer_bench.sv
module irq_sequencer_bench;
  logic clk = 0, rst_n = 0;
  logic [3:0] irq_req = 0, irq_en = 0;
  logic boundary = 0, reti = 0, gie_set = 0, gie_clr = 0, sreg_we = 0;
  logic [15:0] next_pc = 0;
  logic [7:0] sreg_wdata = 0;
  logic [7:0] sreg;
  logic [3:0] pending;
  logic busy, pc_load;
  logic [15:0] pc_target;
  logic [3:0] sp;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  irq_sequencer u_irq_sequencer (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en), .boundary(boundary),
    .next_pc(next_pc), .reti(reti), .gie_set(gie_set), .gie_clr(gie_clr), .sreg_we(sreg_we),
    .sreg_wdata(sreg_wdata), .sreg(sreg), .pending(pending), .busy(busy), .pc_load(pc_load),
    .pc_target(pc_target), .sp(sp));

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step; @(negedge clk); endtask

  task automatic strobe_gie(bit s, bit c);
    gie_set = s; gie_clr = c; step(); gie_set = 0; gie_clr = 0;
  endtask

  task automatic request(logic [3:0] m);
    irq_req = m; step(); irq_req = 0;
  endtask

  task automatic entry(logic [15:0] npc, logic [15:0] exp_tgt, logic [3:0] sp0, logic [3:0] exp_pend, string tag);
    next_pc = npc; boundary = 1; step(); boundary = 0;
    chk({tag, " R3 busy c1"}, busy, 1);
    chk({tag, " R4 gie cleared"}, sreg[7], 0);
    chk({tag, " R8 pending after take"}, pending, exp_pend);
    chk({tag, " R6 no load c1"}, pc_load, 0);
    boundary = 1; step(); boundary = 0;
    chk({tag, " R5 sp after low"}, sp, sp0 - 4'd1);
    step();
    chk({tag, " R6 load"}, pc_load, 1);
    chk({tag, " R6 target"}, pc_target, exp_tgt);
    chk({tag, " R5 sp after high"}, sp, sp0 - 4'd2);
    step();
    chk({tag, " R3 busy end"}, busy, 0);
    chk({tag, " R3 boundary ignored"}, pending, exp_pend);
  endtask

  task automatic do_reti(logic [15:0] exp_pc, logic [3:0] sp0);
    reti = 1; step(); reti = 0;
    chk("R9 busy", busy, 1);
    step(); step();
    chk("R9 load", pc_load, 1);
    chk("R9 popped pc", pc_target, exp_pc);
    chk("R9 sp", sp, sp0 + 4'd2);
    step();
    chk("R9 gie set", sreg[7], 1);
    chk("R9 idle", busy, 0);
  endtask

  task automatic t_reset;
    chk("R5 reset sp", sp, 4'hF);
    chk("reset sreg", sreg, 0);
    chk("reset pending", pending, 0);
    chk("reset busy", busy, 0);
    chk("reset load", pc_load, 0);
  endtask

  task automatic t_masked;
    irq_en = 4'hF;
    request(4'b0010);
    chk("R2 latched while gie off", pending, 4'b0010);
    boundary = 1; step(); boundary = 0;
    chk("R1 no entry with gie off", busy, 0);
    strobe_gie(1, 0);
    chk("R10 set", sreg[7], 1);
    irq_en = 0;
    boundary = 1; step(); boundary = 0;
    chk("R1 no entry with source off", busy, 0);
    chk("R2 flag held", pending, 4'b0010);
    irq_en = 4'b0010;
    step();
    chk("R1 no entry without boundary", busy, 0);
  endtask

  task automatic t_nested;
    entry(16'h1234, 16'h0004, 4'hF, 4'b0000, "src1");
    strobe_gie(1, 0);
    irq_en = 4'hF;
    request(4'b0101);
    entry(16'hABCD, 16'h0002, 4'hD, 4'b0100, "src0 over src2");
    do_reti(16'hABCD, 4'hB);
    strobe_gie(0, 1);
    do_reti(16'h1234, 4'hD);
    entry(16'h0F0F, 16'h0006, 4'hF, 4'b0000, "src2");
    strobe_gie(1, 0);
    request(4'b1000);
    entry(16'h2222, 16'h0000, 4'hD, 4'b0000, "R7 src3 unpopulated");
    do_reti(16'h2222, 4'hB);
    do_reti(16'h0F0F, 4'hD);
  endtask

  task automatic t_status;
    strobe_gie(1, 1);
    chk("R10 clear wins", sreg[7], 0);
    sreg_we = 1; sreg_wdata = 8'h5A; step(); sreg_we = 0;
    chk("R11 write", sreg, 8'h5A);
    sreg_we = 1; sreg_wdata = 8'h3C; gie_set = 1; step(); sreg_we = 0; gie_set = 0;
    chk("R11 strobe overrides bit7", sreg, 8'hBC);
  endtask

  initial begin
    #2000000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    step(); step();
    rst_n = 1;
    step();
    t_reset();
    t_masked();
    t_nested();
    t_status();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule